// File: doc/BRIEF.md
# Barrel Shift Unit with Carry

This block shapes the second operand of a 32-bit integer datapath. Each request carries a value, a shift kind, an amount and the current carry flag. The block returns the shifted value and the carry that the shift produces. Five kinds are supported: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag. The amount comes either from a 5-bit immediate field or from a 32-bit register operand. Only the low byte of the register operand is used, so register amounts reach 255.

Requests enter on a valid/ready handshake, and results leave on another one through a single output register. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears on the following cycle. `in_ready` is high whenever the output register is empty, or when its content leaves in the same cycle (`out_ready` high). If `out_ready` is low, the pending result is held unchanged and new requests are stalled. Results leave in the order the requests were accepted.

Top module: `barrel_shift_unit`

## Requirements
- R1: Kind code 0 is logical left. For an amount n in 1..31 the result is the value shifted left by n with zeros filled in, and the carry is the value's bit 32-n. Example: 0x00000030 shifted by 2 gives 0x000000C0.
- R2: Kind code 1 is logical right. For n in 1..31 the result is filled with zeros from the top, and the carry is the value's bit n-1. Example: 0x00000030 shifted by 2 gives 0x0000000C.
- R3: Kind code 2 is arithmetic right. For n in 1..31 the sign bit is replicated into the vacated bits, and the carry is bit n-1. Example: 0xA0000030 shifted by 2 gives 0xE800000C.
- R4: Kind code 3 is rotate right. For an amount whose value modulo 32 is nonzero, the value rotates by that count, and the carry equals the result's bit 31. Example: 0x00000031 rotated by 2 gives 0x4000000C.
- R5: Kind code 4 rotates right by one bit through the carry. The incoming carry enters bit 31, and the carry out is the original bit 0. The amount is ignored. Example: 0x00000031 with carry 1 gives 0x80000018 with carry 1.
- R6: For kinds 0 to 3, an effective amount of 0 passes the value through unchanged, and the carry out equals the carry in.
- R7: `in_amt_src`=0 selects the 5-bit immediate. `in_amt_src`=1 selects the register operand, of which only bits [7:0] count.
- R8: A logical shift by exactly 32 gives zero. Its carry is bit 0 for left and bit 31 for right. A logical shift above 32 gives zero with carry 0.
- R9: An arithmetic right shift by 32 or more gives every bit equal to the sign bit, with carry equal to the sign bit.
- R10: A rotate by a nonzero multiple of 32 leaves the value unchanged, with carry equal to bit 31.
- R11: Kind codes 5 to 7 pass the value through unchanged, with carry out equal to carry in.
- R12: `in_ready` equals `!out_valid || out_ready`. An accepted request's result is valid on the next cycle. While `out_valid` is high and `out_ready` is low, the output value and carry stay stable.
- R13: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_value | input | 32 | Operand to shift |
| in_kind | input | 3 | Shift kind code (0 to 4, others pass through) |
| in_amt_src | input | 1 | 0: immediate amount, 1: register amount |
| in_imm_amt | input | 5 | Immediate shift amount |
| in_reg_amt | input | 32 | Register amount operand (low byte used) |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_value | output | 32 | Shifted value |
| out_carry | output | 1 | Shifter carry out |

## Verification
Every result becomes visible one clock edge after its request is accepted. It then stays visible until the consumer takes it, so its due cycle depends only on the two handshakes. The driver samples `in_ready` away from the edge to learn on which edge a request is taken, and only then queues the expected item. The monitor compares on each cycle in which `out_valid` and `out_ready` are both high, and additionally checks that a stalled result does not change between cycles. `out_ready` moves in a separate phase after each edge, so stalls of random length exercise the hold rule.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam logic [2:0] KIND_LSL = 3'd0;
  localparam logic [2:0] KIND_LSR = 3'd1;
  localparam logic [2:0] KIND_ASR = 3'd2;
  localparam logic [2:0] KIND_ROR = 3'd3;
  localparam logic [2:0] KIND_RRX = 3'd4;
  localparam int unsigned KIND_W  = 3;
endpackage

// File: rtl/bsu_amount_sel.sv
module bsu_amount_sel #(
  parameter int unsigned IMM_W = 5,
  parameter int unsigned REG_W = 32,
  parameter int unsigned AMT_W = 8
) (
  input  logic             src_reg,
  input  logic [IMM_W-1:0] imm_amt,
  input  logic [REG_W-1:0] reg_amt,
  output logic [AMT_W-1:0] amt
);
  // only the low byte of the register operand is significant
  always_comb begin
    if (src_reg) amt = reg_amt[AMT_W-1:0];
    else         amt = {{(AMT_W-IMM_W){1'b0}}, imm_amt};
  end
endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AMT_W = 8
) (
  input  logic [WIDTH-1:0]  value,
  input  logic [KIND_W-1:0] kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              cin,
  output logic [WIDTH-1:0]  res,
  output logic              cout
);
  localparam int unsigned ROT_W = $clog2(WIDTH);

  logic [WIDTH:0]          lsl_ext;
  logic [WIDTH:0]          lsr_ext;
  logic signed [WIDTH:0]   asr_src;
  logic signed [WIDTH:0]   asr_ext;
  logic [ROT_W-1:0]        rot;
  logic [2*WIDTH-1:0]      ror_ext;
  logic                    amt_zero;

  // extra bit beside the operand catches the last bit shifted out
  assign lsl_ext  = {1'b0, value} << amt;
  assign lsr_ext  = {value, 1'b0} >> amt;
  assign asr_src  = {value, 1'b0};
  assign asr_ext  = asr_src >>> amt;
  assign rot      = amt[ROT_W-1:0];
  assign ror_ext  = {value, value} >> rot;
  assign amt_zero = (amt == '0);

  always_comb begin
    res  = value;
    cout = cin;
    unique case (kind)
      KIND_LSL: if (!amt_zero) {cout, res} = lsl_ext;
      KIND_LSR: if (!amt_zero) {res, cout} = lsr_ext;
      KIND_ASR: if (!amt_zero) {res, cout} = asr_ext;
      KIND_ROR: begin
        if (!amt_zero) begin
          if (rot == '0) begin
            res  = value;
            cout = value[WIDTH-1];
          end else begin
            res  = ror_ext[WIDTH-1:0];
            cout = ror_ext[WIDTH-1];
          end
        end
      end
      KIND_RRX: begin
        res  = {cin, value[WIDTH-1:1]};
        cout = value[0];
      end
      default: begin
        res  = value;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/bsu_out_reg.sv
module bsu_out_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  output logic             d_ready,
  input  logic [WIDTH-1:0] d_value,
  input  logic             d_carry,
  output logic             q_valid,
  input  logic             q_ready,
  output logic [WIDTH-1:0] q_value,
  output logic             q_carry
);
  assign d_ready = !q_valid || q_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_value <= '0;
      q_carry <= 1'b0;
    end else if (d_ready) begin
      q_valid <= d_valid;
      if (d_valid) begin
        q_value <= d_value;
        q_carry <= d_carry;
      end
    end
  end

  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> (q_valid && $stable(q_value) && $stable(q_carry)));

  assert_accept_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_ready) |=> q_valid);
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import bsu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AMT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WIDTH-1:0]  in_value,
  input  logic [KIND_W-1:0] in_kind,
  input  logic              in_amt_src,
  input  logic [$clog2(WIDTH)-1:0] in_imm_amt,
  input  logic [WIDTH-1:0]  in_reg_amt,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDTH-1:0]  out_value,
  output logic              out_carry
);
  localparam int unsigned IMM_W = $clog2(WIDTH);

  logic [AMT_W-1:0] eff_amt;
  logic [WIDTH-1:0] sh_value;
  logic             sh_carry;
  logic             accept;

  bsu_amount_sel #(.IMM_W(IMM_W), .REG_W(WIDTH), .AMT_W(AMT_W)) u_amt (
    .src_reg (in_amt_src),
    .imm_amt (in_imm_amt),
    .reg_amt (in_reg_amt),
    .amt     (eff_amt)
  );

  bsu_datapath #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dp (
    .value (in_value),
    .kind  (in_kind),
    .amt   (eff_amt),
    .cin   (in_carry),
    .res   (sh_value),
    .cout  (sh_carry)
  );

  bsu_out_reg #(.WIDTH(WIDTH)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (in_valid),
    .d_ready (in_ready),
    .d_value (sh_value),
    .d_carry (sh_carry),
    .q_valid (out_valid),
    .q_ready (out_ready),
    .q_value (out_value),
    .q_carry (out_carry)
  );

  assign accept = in_valid && in_ready;

  assert_rrx_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == KIND_RRX) |=>
      (out_carry == $past(in_value[0]) && out_value[WIDTH-1] == $past(in_carry)));

  assert_zero_amount_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind != KIND_RRX && eff_amt == '0) |=>
      (out_value == $past(in_value) && out_carry == $past(in_carry)));

  assert_asr_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == KIND_ASR && eff_amt >= AMT_W'(WIDTH)) |=>
      (out_value == {WIDTH{$past(in_value[WIDTH-1])}} && out_carry == $past(in_value[WIDTH-1])));

  assert_other_kinds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind > KIND_RRX) |=>
      (out_value == $past(in_value) && out_carry == $past(in_carry)));
endmodule

// File: tb/test_barrel_shift_unit.sv
module test_barrel_shift_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string      tag;
    logic [31:0] value;
    logic        carry;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_value = '0;
  logic [2:0]  in_kind = '0;
  logic        in_amt_src = 1'b0;
  logic [4:0]  in_imm_amt = '0;
  logic [31:0] in_reg_amt = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_value;
  logic        out_carry;

  int   tests = 0;
  int   fails = 0;
  bit   bp = 1'b0;
  exp_t sb[$];
  bit          held_pending = 1'b0;
  logic [31:0] held_value;
  logic        held_carry;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_shift_unit i_barrel_shift_unit (
    .clk, .rst_n, .in_valid, .in_ready, .in_value, .in_kind, .in_amt_src,
    .in_imm_amt, .in_reg_amt, .in_carry, .out_valid, .out_ready,
    .out_value, .out_carry
  );

  // bit-serial reference written from the requirements
  function automatic void model(input logic [31:0] v, input logic [2:0] k,
      input logic src, input logic [4:0] imm, input logic [31:0] ra,
      input logic c, output logic [31:0] r, output logic co);
    int n;
    n  = src ? int'(ra[7:0]) : int'(imm);
    r  = v;
    co = c;
    case (k)
      3'd0: for (int i = 0; i < n; i++) begin co = r[31]; r = {r[30:0], 1'b0}; end
      3'd1: for (int i = 0; i < n; i++) begin co = r[0]; r = {1'b0, r[31:1]}; end
      3'd2: for (int i = 0; i < n; i++) begin co = r[0]; r = {r[31], r[31:1]}; end
      3'd3: if (n != 0) begin
        if (n % 32 == 0) co = r[31];
        else for (int i = 0; i < n % 32; i++) begin co = r[0]; r = {r[0], r[31:1]}; end
      end
      3'd4: begin co = v[0]; r = {c, v[31:1]}; end
      default: ;
    endcase
  endfunction

  task automatic check(input string tag, input bit ok, input logic [31:0] act,
      input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [31:0] v, input logic [2:0] k,
      input logic src, input logic [4:0] imm, input logic [31:0] ra, input logic c);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_value = v; in_kind = k; in_amt_src = src;
    in_imm_amt = imm; in_reg_amt = ra; in_carry = c;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e.tag = tag;
    model(v, k, src, imm, ra, c, e.value, e.carry);
    sb.push_back(e);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  function automatic string tag_of(input logic [2:0] k, input logic src,
      input logic [4:0] imm, input logic [31:0] ra);
    int n;
    n = src ? int'(ra[7:0]) : int'(imm);
    if (k == 3'd4) return "R5";
    if (k > 3'd4)  return "R11";
    if (n == 0)    return "R6";
    if (k == 3'd3) return (n % 32 == 0) ? "R10" : "R4";
    if (n >= 32)   return (k == 3'd2) ? "R9" : "R8";
    if (k == 3'd0) return "R1";
    if (k == 3'd1) return "R2";
    return "R3";
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      check("R12 in_ready rule", in_ready === (!out_valid || out_ready),
            {31'd0, in_ready}, {31'd0, !out_valid || out_ready});
      if (held_pending) begin
        check("R12 stalled result stable",
              out_valid === 1'b1 && out_value === held_value && out_carry === held_carry,
              out_value, held_value);
      end
      held_pending = out_valid && !out_ready;
      held_value   = out_value;
      held_carry   = out_carry;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check("R12 unexpected result", 1'b0, out_value, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " value"}, out_value === e.value, out_value, e.value);
          check({e.tag, " carry"}, out_carry === e.carry, {31'd0, out_carry}, {31'd0, e.carry});
        end
      end
    end
  end

  // consumer back-pressure
  initial begin
    forever begin
      @(posedge clk);
      #2;
      out_ready = bp ? 1'($urandom % 2) : 1'b1;
    end
  end

  // watchdog
  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13 out_valid in reset", out_valid === 1'b0, {31'd0, out_valid}, 32'd0);
    check("R13 in_ready in reset", in_ready === 1'b1, {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 out_valid after reset", out_valid === 1'b0, {31'd0, out_valid}, 32'd0);

    send("R1",  32'h0000_0030, 3'd0, 1'b0, 5'd2,  32'hDEAD_BEEF, 1'b1);
    send("R1",  32'h0000_0003, 3'd0, 1'b0, 5'd31, 32'h0, 1'b0);
    send("R2",  32'h0000_0030, 3'd1, 1'b0, 5'd2,  32'h0, 1'b1);
    send("R2",  32'hC000_0000, 3'd1, 1'b0, 5'd31, 32'h0, 1'b0);
    send("R3",  32'hA000_0030, 3'd2, 1'b0, 5'd2,  32'h0, 1'b0);
    send("R4",  32'h0000_0031, 3'd3, 1'b0, 5'd2,  32'h0, 1'b0);
    send("R4",  32'h0000_0006, 3'd3, 1'b1, 5'd0,  32'h0000_0022, 1'b1);
    send("R5",  32'h0000_0031, 3'd4, 1'b0, 5'd0,  32'h0, 1'b1);
    send("R5",  32'h0000_0030, 3'd4, 1'b1, 5'd0,  32'h0000_0007, 1'b0);
    send("R6",  32'h1234_5678, 3'd0, 1'b0, 5'd0,  32'hFFFF_FF01, 1'b1);
    send("R6",  32'h8765_4321, 3'd2, 1'b1, 5'd9,  32'hFFFF_FF00, 1'b0);
    send("R7",  32'h0000_0001, 3'd0, 1'b1, 5'd0,  32'hFFFF_FF04, 1'b0);
    send("R7",  32'h0000_0001, 3'd0, 1'b0, 5'd3,  32'h0000_0040, 1'b0);
    send("R8",  32'h0000_0001, 3'd0, 1'b1, 5'd0,  32'd32, 1'b0);
    send("R8",  32'h8000_0000, 3'd1, 1'b1, 5'd0,  32'd32, 1'b0);
    send("R8",  32'hFFFF_FFFF, 3'd0, 1'b1, 5'd0,  32'd33, 1'b1);
    send("R8",  32'hFFFF_FFFF, 3'd1, 1'b1, 5'd0,  32'd255, 1'b1);
    send("R9",  32'h8000_0001, 3'd2, 1'b1, 5'd0,  32'd40, 1'b0);
    send("R9",  32'h7FFF_FFFF, 3'd2, 1'b1, 5'd0,  32'd200, 1'b1);
    send("R10", 32'h8000_0001, 3'd3, 1'b1, 5'd0,  32'd64, 1'b0);
    send("R10", 32'h4000_0001, 3'd3, 1'b1, 5'd0,  32'd32, 1'b1);
    send("R11", 32'hCAFE_F00D, 3'd5, 1'b0, 5'd4,  32'h0, 1'b1);
    send("R11", 32'h0BAD_0001, 3'd7, 1'b1, 5'd0,  32'd8, 1'b0);

    for (int p = 0; p < 2; p++) begin
      bp = (p == 1);
      for (int i = 0; i < 400; i++) begin
        logic [2:0] k; logic s; logic [4:0] im; logic [31:0] ra, v;
        k  = 3'($urandom % 8);
        s  = 1'($urandom % 2);
        im = 5'($urandom);
        ra = $urandom;
        v  = $urandom;
        send(tag_of(k, s, im, ra), v, k, s, im, ra, 1'($urandom % 2));
      end
    end
    bp = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule